// File: doc/BRIEF.md
# Half-Duplex Bidirectional Line Repeater

This block sits between a host controller and a card socket and joins three open-drain data channels: one main data channel and two auxiliary channels. Every line idles high through a pull-up, so the repeater only ever pulls a line low, except for a short high pulse. Each channel works out for itself which side is talking. The first side to pull its line low while both lines are high becomes master, and the repeater copies that low onto the other side. When the master lets go, the repeater stops driving the far line and then actively drives it high for a fixed number of cycles, so that the rising edge is sharp. A guard interval follows. During it the echoed rising edge, still working its way through the input synchronisers, cannot be taken for a new transfer started from the other side.

A card-enable input comes from the activation sequencer. While it is low, every card-side line is held low and nothing from the host is passed on. Each channel runs its own state machine. The states are ST_OFF (card inactive), ST_IDLE (both lines high, waiting), ST_HOST_MST (host is master, card line pulled low), ST_CARD_MST (card is master, host line pulled low), ST_PU_CARD and ST_PU_HOST (active pull-up on the line that was slave), and ST_GUARD (direction still locked, inputs ignored). The transitions are:
- ST_OFF to ST_GUARD when the card is enabled.
- ST_IDLE to ST_HOST_MST on a sensed host low. ST_IDLE to ST_CARD_MST on a sensed card low, but only while the host line is high.
- ST_HOST_MST to ST_PU_CARD, and ST_CARD_MST to ST_PU_HOST, when the master line is sensed high.
- ST_PU_CARD or ST_PU_HOST to ST_GUARD when the pulse count runs out.
- ST_GUARD to ST_IDLE when the guard count runs out.
- Any state to ST_OFF when the card is disabled.

Top module: `bidir_line_repeater`

## Requirements
- R1: After reset every channel is in ST_OFF. All card_drv_lo bits are 1, and all host_drv_lo, host_pu and card_pu bits are 0.
- R2: A host line that goes low while its channel is idle makes that channel's card_drv_lo 1 exactly 3 rising clock edges later: two synchroniser stages plus one state register, 24 ns at 125 MHz, well inside 200 ns. The output is still 0 after 2 edges.
- R3: A card line that goes low while its channel is idle and its host line is high makes that channel's host_drv_lo 1 exactly 3 rising edges later.
- R4: After the master line returns high, the far-side drive-low drops 3 edges later. In the same cycle the far-side pull-up enable (card_pu for a host master, host_pu for a card master) rises and stays 1 for exactly PULSE_CYC cycles (12 by default). The master-side pull-up stays 0.
- R5: While one side is master, a low on the other side's line has no effect: that side's drive-low stays 0.
- R6: After a release, the master side's drive-low stays 0 through the pulse and the GUARD_CYC guard cycles (4 by default), even though the released far line rises late through its synchroniser.
- R7: If both lines of an idle channel go low in the same cycle, the host side wins. card_drv_lo becomes 1 and host_drv_lo stays 0.
- R8: One edge after card_en is sampled low, every channel has card_drv_lo=1, host_drv_lo=0 and both pull-ups 0, and host lows are not forwarded.
- R9: When card_en rises, each channel passes through ST_GUARD before ST_IDLE. The card lines, which were low in ST_OFF, therefore do not produce a host_drv_lo pulse.
- R10: Channels are independent. Traffic on one channel in either direction leaves the outputs of the others unchanged.
- R11: A channel reproduces a 1 MHz toggle train (62-cycle low, 63-cycle high halves), with each low copied after the same 3-edge latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_en | input | 1 | Card active, from the activation sequencer |
| host_in | input | NUM_CH | Sensed level of each host-side line |
| host_drv_lo | output | NUM_CH | Pull the host-side line low |
| host_pu | output | NUM_CH | Active pull-up pulse on the host-side line |
| card_in | input | NUM_CH | Sensed level of each card-side line |
| card_drv_lo | output | NUM_CH | Pull the card-side line low |
| card_pu | output | NUM_CH | Active pull-up pulse on the card-side line |

## Verification
Directed transfers in both directions separate forwarding latency from pulse length, and show whether the pulse lands on the correct side. Holding the slave low during a transfer, lowering both lines in the same cycle, and watching the master side through the guard window tell the lock, the tie rule and the echo suppression apart. Dropping card_en in the middle of a transfer and raising it again tests the hold-low state and the guarded exit from it. Random transfers on random channels and in random directions, with random low lengths, plus a 1 MHz toggle train, exercise direction choice repeatedly while the other channels are checked for stray activity.

// File: rtl/repeater_pkg.sv
package repeater_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_HOST_MST,
        ST_CARD_MST,
        ST_PU_CARD,
        ST_PU_HOST,
        ST_GUARD
    } rep_state_e;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // Lines idle high, so the chain resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/chan_fsm.sv
module chan_fsm
    import repeater_pkg::*;
#(
    parameter int PULSE_CYC = 12,
    parameter int GUARD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_en,
    input  logic h_sense,
    input  logic c_sense,
    output logic h_drv_lo,
    output logic h_pu,
    output logic c_drv_lo,
    output logic c_pu
);
    localparam int MAXC = (PULSE_CYC > GUARD_CYC) ? PULSE_CYC : GUARD_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    rep_state_e    state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        if (!card_en) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: begin
                    nxt     = ST_GUARD;
                    cnt_nxt = CW'(GUARD_CYC - 1);
                end
                ST_IDLE: begin
                    if (!h_sense)      nxt = ST_HOST_MST;
                    else if (!c_sense) nxt = ST_CARD_MST;
                end
                ST_HOST_MST: if (h_sense) begin
                    nxt     = ST_PU_CARD;
                    cnt_nxt = CW'(PULSE_CYC - 1);
                end
                ST_CARD_MST: if (c_sense) begin
                    nxt     = ST_PU_HOST;
                    cnt_nxt = CW'(PULSE_CYC - 1);
                end
                ST_PU_CARD, ST_PU_HOST: begin
                    if (cnt == '0) begin
                        nxt     = ST_GUARD;
                        cnt_nxt = CW'(GUARD_CYC - 1);
                    end else begin
                        cnt_nxt = cnt - 1'b1;
                    end
                end
                ST_GUARD: begin
                    if (cnt == '0) nxt = ST_IDLE;
                    else           cnt_nxt = cnt - 1'b1;
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        h_drv_lo = 1'b0;
        h_pu     = 1'b0;
        c_drv_lo = 1'b0;
        c_pu     = 1'b0;
        unique case (state)
            ST_OFF:      c_drv_lo = 1'b1;
            ST_HOST_MST: c_drv_lo = 1'b1;
            ST_CARD_MST: h_drv_lo = 1'b1;
            ST_PU_CARD:  c_pu     = 1'b1;
            ST_PU_HOST:  h_pu     = 1'b1;
            default: ;
        endcase
    end

    // Length of the current run of pull-up cycles, for the pulse check.
    logic [CW:0] pu_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             pu_run <= '0;
        else if (h_pu || c_pu)  pu_run <= pu_run + 1'b1;
        else                    pu_run <= '0;
    end

    assert_no_both_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_drv_lo && c_drv_lo));
    assert_off_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !card_en |=> (c_drv_lo && !h_drv_lo && !h_pu && !c_pu));
    assert_host_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !h_sense) |=> c_drv_lo);
    assert_card_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && h_sense && !c_sense && card_en) |=> h_drv_lo);
    assert_pulse_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOST_MST && h_sense && card_en) |=> (c_pu && !h_pu && !c_drv_lo));
    assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pu_run <= (CW+1)'(PULSE_CYC));
    assert_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOST_MST && !h_sense && card_en) |=> !h_drv_lo);
    assert_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && card_en) |=> (!h_drv_lo && !c_drv_lo));
endmodule

// File: rtl/bidir_line_repeater.sv
module bidir_line_repeater #(
    parameter int NUM_CH      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_CYC   = 12,
    parameter int GUARD_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_en,
    input  logic [NUM_CH-1:0] host_in,
    output logic [NUM_CH-1:0] host_drv_lo,
    output logic [NUM_CH-1:0] host_pu,
    input  logic [NUM_CH-1:0] card_in,
    output logic [NUM_CH-1:0] card_drv_lo,
    output logic [NUM_CH-1:0] card_pu
);
    localparam int SW = 2 * NUM_CH;

    logic [SW-1:0] sensed;

    line_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({card_in, host_in}),
        .q    (sensed)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        chan_fsm #(.PULSE_CYC(PULSE_CYC), .GUARD_CYC(GUARD_CYC)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .card_en (card_en),
            .h_sense (sensed[g]),
            .c_sense (sensed[NUM_CH+g]),
            .h_drv_lo(host_drv_lo[g]),
            .h_pu    (host_pu[g]),
            .c_drv_lo(card_drv_lo[g]),
            .c_pu    (card_pu[g])
        );
    end

    // R10: one channel's traffic never drives another channel's lines.
    assert_ch_indep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (card_en && $stable(card_en) && (host_in == '1) && (card_in == '1) && $past(host_in == '1) && $past(card_in == '1)
         && $past(host_drv_lo == '0) && $past(card_drv_lo == '0))
        |=> ($countones(host_drv_lo) == 0 || $past(host_in != '1) || $past(card_in != '1)));
endmodule

// File: tb/bidir_line_repeater_tb.sv
module bidir_line_repeater_tb;
    localparam int NCH   = 3;
    localparam int PULSE = 12;
    localparam int GUARD = 4;
    localparam int SYNC  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_en = 1'b0;
    logic [NCH-1:0] host_ext_lo = '0, card_ext_lo = '0;
    logic [NCH-1:0] host_in, card_in, host_drv_lo, host_pu, card_drv_lo, card_pu;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    // Open-drain lines with weak pull-ups: high unless someone pulls low.
    assign host_in = ~(host_ext_lo | host_drv_lo);
    assign card_in = ~(card_ext_lo | card_drv_lo);

    bidir_line_repeater #(.NUM_CH(NCH), .SYNC_STAGES(SYNC), .PULSE_CYC(PULSE), .GUARD_CYC(GUARD)) u_dut (
        .clk(clk), .rst_n(rst_n), .card_en(card_en),
        .host_in(host_in), .host_drv_lo(host_drv_lo), .host_pu(host_pu),
        .card_in(card_in), .card_drv_lo(card_drv_lo), .card_pu(card_pu));

    function automatic int exp_latency();
        return SYNC + 1;
    endfunction
    function automatic int exp_pulse();
        return PULSE;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic nwait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_quiet(input int ch, input string req);
        for (int k = 0; k < NCH; k++) if (k != ch) begin
            chk({host_drv_lo[k], card_drv_lo[k], host_pu[k], card_pu[k]} == 4'b0, req,
                {host_drv_lo[k], card_drv_lo[k], host_pu[k], card_pu[k]}, 0);
        end
    endtask

    // One transfer on channel ch, led by the host (from_host=1) or the card.
    task automatic transfer(input int ch, input bit from_host, input int low_len);
        int run;
        string rq;
        rq = from_host ? "R2" : "R3";
        @(negedge clk);
        if (from_host) host_ext_lo[ch] = 1'b1; else card_ext_lo[ch] = 1'b1;
        nwait(exp_latency() - 1);
        chk((from_host ? card_drv_lo[ch] : host_drv_lo[ch]) == 1'b0, rq, 1, 0);
        nwait(1);
        chk((from_host ? card_drv_lo[ch] : host_drv_lo[ch]) == 1'b1, rq, 0, 1);
        chk_quiet(ch, "R10");
        nwait(low_len - exp_latency());
        if (from_host) host_ext_lo[ch] = 1'b0; else card_ext_lo[ch] = 1'b0;
        nwait(exp_latency());
        chk((from_host ? card_drv_lo[ch] : host_drv_lo[ch]) == 1'b0, "R4", 1, 0);
        run = 0;
        while ((from_host ? card_pu[ch] : host_pu[ch]) && run < 100) begin
            chk((from_host ? host_pu[ch] : card_pu[ch]) == 1'b0, "R4", 1, 0);
            chk((from_host ? host_drv_lo[ch] : card_drv_lo[ch]) == 1'b0, "R6", 1, 0);
            run++;
            nwait(1);
        end
        chk(run == exp_pulse(), "R4", run, exp_pulse());
        for (int i = 0; i < GUARD + 3; i++) begin
            chk((from_host ? host_drv_lo[ch] : card_drv_lo[ch]) == 1'b0, "R6", 1, 0);
            nwait(1);
        end
        chk({host_drv_lo[ch], card_drv_lo[ch], host_pu[ch], card_pu[ch]} == 4'b0, "R6",
            {host_drv_lo[ch], card_drv_lo[ch], host_pu[ch], card_pu[ch]}, 0);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int r;
        nwait(3);
        // R1: reset state
        chk(card_drv_lo == '1, "R1", card_drv_lo, 7);
        chk({host_drv_lo, host_pu, card_pu} == '0, "R1", {host_drv_lo, host_pu, card_pu}, 0);
        rst_n = 1'b1;
        nwait(2);
        // R8: host lows not forwarded while inactive
        host_ext_lo[1] = 1'b1;
        nwait(5);
        chk(card_drv_lo == '1 && host_drv_lo == '0, "R8", {card_drv_lo, host_drv_lo}, 56);
        host_ext_lo[1] = 1'b0;
        nwait(5);
        chk(card_pu == '0, "R8", card_pu, 0);
        // R9: enable; card lines rise late but are not taken as card lows
        card_en = 1'b1;
        for (int i = 0; i < GUARD + 4; i++) begin
            nwait(1);
            chk(host_drv_lo == '0, "R9", host_drv_lo, 0);
        end
        chk(card_drv_lo == '0, "R9", card_drv_lo, 0);
        // R2/R3/R4/R6 directed
        transfer(0, 1'b1, 10);
        transfer(2, 1'b0, 4);
        // R5: slave low during host master has no effect
        @(negedge clk); host_ext_lo[1] = 1'b1;
        nwait(4);
        card_ext_lo[1] = 1'b1;
        nwait(6);
        chk(host_drv_lo[1] == 1'b0 && card_drv_lo[1] == 1'b1, "R5", {host_drv_lo[1], card_drv_lo[1]}, 1);
        card_ext_lo[1] = 1'b0;
        host_ext_lo[1] = 1'b0;
        nwait(PULSE + GUARD + 8);
        // R7: simultaneous lows, host wins
        host_ext_lo[1] = 1'b1; card_ext_lo[1] = 1'b1;
        nwait(exp_latency());
        chk(card_drv_lo[1] == 1'b1 && host_drv_lo[1] == 1'b0, "R7", {card_drv_lo[1], host_drv_lo[1]}, 2);
        card_ext_lo[1] = 1'b0;
        nwait(3);
        host_ext_lo[1] = 1'b0;
        nwait(PULSE + GUARD + 8);
        // R10: two channels in opposite directions at once
        host_ext_lo[0] = 1'b1; card_ext_lo[2] = 1'b1;
        nwait(exp_latency() + 1);
        chk(card_drv_lo == 3'b001 && host_drv_lo == 3'b100, "R10", {card_drv_lo, host_drv_lo}, 12);
        host_ext_lo[0] = 1'b0; card_ext_lo[2] = 1'b0;
        nwait(PULSE + GUARD + 8);
        // R8: drop enable mid-transfer
        host_ext_lo[2] = 1'b1;
        nwait(exp_latency() + 1);
        card_en = 1'b0;
        nwait(1);
        chk(card_drv_lo == '1 && host_drv_lo == '0 && host_pu == '0 && card_pu == '0, "R8",
            {card_drv_lo, host_drv_lo, host_pu, card_pu}, 3584);
        host_ext_lo[2] = 1'b0;
        nwait(3);
        card_en = 1'b1;
        nwait(GUARD + 6);
        chk(card_drv_lo == '0 && host_drv_lo == '0, "R9", {card_drv_lo, host_drv_lo}, 0);
        // R11: 1 MHz toggle train
        for (int i = 0; i < 4; i++) begin
            transfer(1, 1'b1, 62);
            nwait(63 - (exp_latency() + PULSE + GUARD + 4));
        end
        // Random transfers with fixed seed
        r = $urandom(32'h5EED1);
        for (int i = 0; i < 30; i++) begin
            transfer(int'($urandom % NCH), bit'($urandom % 2), 4 + int'($urandom % 60));
            nwait(1 + int'($urandom % 30));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule